// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This block handles data-cache misses. A load that misses starts a refill of the whole line: one bus read per word, eight in the default build. The reads go out in wrapped order, starting with the word the load asked for. That word is therefore acknowledged first. Its data goes back to the requester one cycle later, while the other reads are still outstanding.

Once that early answer is out, the request slot is free again. The state machine stays in refill until every read has been acknowledged. A request that arrives in this tail is parked in a one-entry holding register. It is replayed when the controller returns to idle. A multiplexer chooses what the state machine acts on. If the holding register is occupied, it supplies the request. Otherwise the request on the port this cycle is used, so an empty holder adds no latency.

The line's tag and valid bit are written only when the last acknowledge arrives. A replayed request to the same line then hits and causes no bus traffic. Addresses are word addresses: the low `log2(LINE_WORDS)` bits select the word, the next `log2(SETS)` bits select the set, and the remaining upper bits are the tag. With the defaults this is word bits 2:0, set bits 4:3 and tag bits 9:5. The cache is direct-mapped, and only loads are handled.

Top module: `cwf_refill_ctrl`

## Requirements
- R1: In the first cycle after reset, `req_ready` is 1, `bus_stb` is 0 and `rsp_valid` is 0. While the controller is idle, `bus_stb` stays 0.
- R2: A miss issues exactly LINE_WORDS read strobes, one per cycle. All carry the missed line's tag and set. Their word fields run missed word, missed word+1, and so on, modulo LINE_WORDS.
- R3: The cycle after the first acknowledge of a refill, `rsp_valid` is 1 and `rsp_data` equals that acknowledge's data. This is the missed word, and it arrives while the other acknowledges are still pending.
- R4: After the early response, `req_ready` returns to 1. The controller keeps receiving acknowledges and stays in refill until all LINE_WORDS have arrived.
- R5: A request accepted during the refill tail is stored. From the next cycle `req_ready` is 0 until that request is replayed.
- R6: A stored request is acted on only after the final acknowledge. If it targets the refilled line, it is answered from the cache with the correct word and no new bus reads.
- R7: A stored request to a different line starts its own wrapped refill, and only after every acknowledge of the running refill has arrived.
- R8: A request that hits while the controller is idle, with no stored request, is answered in the next cycle with the stored word and no bus strobe.
- R9: Tag and valid are written only with the final acknowledge. A request to the same set with a different tag misses and refills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_addr | input | ADDR_W | Word address of the load |
| rsp_valid | output | 1 | Load data valid (one cycle) |
| rsp_data | output | DATA_W | Load data |
| bus_stb | output | 1 | Bus read strobe |
| bus_addr | output | ADDR_W | Bus read word address |
| bus_ack | input | 1 | Bus read acknowledge, in issue order |
| bus_data | input | DATA_W | Bus read data, valid with `bus_ack` |

## Verification
The embedded properties check several rules on every cycle. The first acknowledge is forwarded to the response port. The controller cannot leave refill before the last acknowledge. A tail request is captured and the holder is kept until idle. Successive strobes step through the words in wrapped order. Idle hits answer at once, and the control state always agrees with the burst sequencer.

Some behaviour only the bench scenarios can show. These cover the complete order of the strobe addresses for every start word, the data values returned, and whether a replay hits with no new reads or triggers a fresh refill only after the first one ends. They also cover eviction by a conflicting tag.

// File: rtl/cwf_pkg.sv
// Shared types for the critical-word-first refill controller.
package cwf_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REFILL = 1'b1
    } cwf_state_e;
endpackage

// File: rtl/cwf_tag_store.sv
// Direct-mapped tag and valid storage, one entry per set.
// Assumes SETS >= 2. The lookup is combinational; writes happen at the clock edge.
module cwf_tag_store #(
    parameter int SETS  = 4,
    parameter int TAG_W = 5,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [SETS-1:0]  vld;
    logic [TAG_W-1:0] tg [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        // Clear valid on reset; load tag and set valid on a write to this set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[s] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(s)) begin
                vld[s] <= 1'b1;
                tg[s]  <= wr_tag;
            end
        end
    end

    assign lk_hit = vld[lk_idx] && (tg[lk_idx] == lk_tag);
endmodule

// File: rtl/cwf_data_store.sv
// Cache data words: one synchronous write port, one combinational read port.
// The contents are undefined until a refill has written them.
module cwf_data_store #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store one refill word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cwf_burst_seq.sv
// Wrapped burst sequencer. It issues WORDS strobes on consecutive cycles from a start word,
// and counts the in-order acknowledges. It is done when the last acknowledge returns.
// Assumes WORDS is a power of two and that the bus never acknowledges an unissued read.
module cwf_burst_seq #(
    parameter int WORDS = 8,
    localparam int WOFF_W = $clog2(WORDS),
    localparam int CNT_W  = $clog2(WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WOFF_W-1:0] start_word,
    input  logic              ack,
    output logic              run,
    output logic              strobe,
    output logic [WOFF_W-1:0] strobe_word,
    output logic [WOFF_W-1:0] ack_word,
    output logic              ack_first,
    output logic              ack_last
);
    logic [WOFF_W-1:0] base;
    logic [CNT_W-1:0]  issued;
    logic [CNT_W-1:0]  acked;

    assign strobe      = run && (issued != CNT_W'(WORDS));
    assign strobe_word = base + issued[WOFF_W-1:0];
    assign ack_word    = base + acked[WOFF_W-1:0];
    assign ack_first   = run && (acked == '0);
    assign ack_last    = run && (acked == CNT_W'(WORDS - 1));

    // Start a burst, then advance the issue and acknowledge counters until the last acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            base   <= '0;
            issued <= '0;
            acked  <= '0;
        end else if (start && !run) begin
            run    <= 1'b1;
            base   <= start_word;
            issued <= '0;
            acked  <= '0;
        end else if (run) begin
            if (strobe) issued <= issued + 1'b1;
            if (ack) begin
                acked <= acked + 1'b1;
                if (ack_last) run <= 1'b0;
            end
        end
    end

    // R2: successive strobes of a burst step one word forward, wrapping.
    p_wrap_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && issued != '0) |-> (strobe_word == $past(strobe_word) + 1'b1));

    // R4: the final acknowledge comes only after every strobe has gone out.
    p_last_after_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ack_last) |-> !strobe);
endmodule

// File: rtl/cwf_refill_ctrl.sv
// Critical-word-first line refill controller for a direct-mapped data cache (loads only).
// A miss refills the line in wrapped order from the missed word and answers the load
// on the first acknowledge. A request that arrives during the rest of the refill waits
// in a one-entry holder and is replayed once the refill completes.
// Assumes in-order bus acknowledges, LINE_WORDS a power of two, and SETS >= 2.
module cwf_refill_ctrl
    import cwf_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 10,
    parameter int LINE_WORDS = 8,
    parameter int SETS       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              bus_stb,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_data
);
    localparam int WOFF_W = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - WOFF_W - IDX_W;
    localparam int LINE_W = ADDR_W - WOFF_W;
    localparam int DEPTH  = SETS * LINE_WORDS;

    cwf_state_e        state;
    logic [LINE_W-1:0] line_r;
    logic              crit_done;
    logic              held_v;
    logic [ADDR_W-1:0] held_addr;

    logic              sel_v, act, hit;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] rd_word;
    logic              seq_run, seq_stb, ack_first, ack_last;
    logic [WOFF_W-1:0] stb_word, ack_word;

    // The slot is free when idle or once the critical word has been answered, provided nothing is held.
    assign req_ready = !held_v && (state == ST_IDLE || crit_done);
    // Choose the request to act on: the held one first, otherwise the one arriving now.
    assign sel_v    = held_v || (req_valid && req_ready);
    assign sel_addr = held_v ? held_addr : req_addr;
    assign act      = (state == ST_IDLE) && sel_v;

    cwf_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .lk_idx (sel_addr[WOFF_W +: IDX_W]),
        .lk_tag (sel_addr[ADDR_W-1 -: TAG_W]),
        .lk_hit (hit),
        .wr_en  (bus_ack && ack_last),
        .wr_idx (line_r[IDX_W-1:0]),
        .wr_tag (line_r[LINE_W-1 -: TAG_W])
    );

    cwf_data_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
        .clk   (clk),
        .we    (bus_ack && seq_run),
        .waddr ({line_r[IDX_W-1:0], ack_word}),
        .wdata (bus_data),
        .raddr (sel_addr[WOFF_W + IDX_W - 1:0]),
        .rdata (rd_word)
    );

    cwf_burst_seq #(.WORDS(LINE_WORDS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (act && !hit),
        .start_word  (sel_addr[WOFF_W-1:0]),
        .ack         (bus_ack),
        .run         (seq_run),
        .strobe      (seq_stb),
        .strobe_word (stb_word),
        .ack_word    (ack_word),
        .ack_first   (ack_first),
        .ack_last    (ack_last)
    );

    assign bus_stb  = seq_stb;
    assign bus_addr = {line_r, stb_word};

    // Control: serve hits, start refills, answer early, hold tail requests, and return to idle on the last acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            line_r    <= '0;
            crit_done <= 1'b0;
            held_v    <= 1'b0;
            held_addr <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (act) begin
                        held_v <= 1'b0;
                        if (hit) begin
                            rsp_valid <= 1'b1;
                            rsp_data  <= rd_word;
                        end else begin
                            state     <= ST_REFILL;
                            line_r    <= sel_addr[ADDR_W-1:WOFF_W];
                            crit_done <= 1'b0;
                        end
                    end
                end
                default: begin
                    if (req_valid && req_ready) begin
                        held_v    <= 1'b1;
                        held_addr <= req_addr;
                    end
                    if (bus_ack && ack_first) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= bus_data;
                        crit_done <= 1'b1;
                    end
                    if (bus_ack && ack_last) state <= ST_IDLE;
                end
            endcase
        end
    end

    // R1: no bus traffic while idle.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !bus_stb);
    // R3: the first acknowledge is forwarded on the next cycle.
    p_early_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REFILL && bus_ack && !crit_done) |=> (rsp_valid && rsp_data == $past(bus_data)));
    // R4: refill persists until the final acknowledge.
    p_stay_refill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REFILL && !(bus_ack && ack_last)) |=> (state == ST_REFILL));
    // R4: control state and burst sequencer agree.
    p_state_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REFILL) == seq_run);
    // R5: a tail request is captured and blocks further requests.
    p_tail_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REFILL && req_valid && req_ready) |=> (held_v && !req_ready));
    // R6: the holder is kept for as long as the refill runs.
    p_no_early_replay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (held_v && state == ST_REFILL) |=> held_v);
    // R8: an idle hit answers next cycle without touching the bus.
    p_idle_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act && hit) |=> (rsp_valid && !bus_stb));
endmodule

// File: tb/sim_cwf_refill_ctrl.sv
// Self-checking bench: wrapped refills from every start word, with several ack latencies,
// idle hits, tail requests to the same line and to another line, and set conflicts.
module sim_cwf_refill_ctrl;
    localparam int DW = 32;
    localparam int AW = 10;
    localparam int NW = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n     = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr  = '0;
    logic          req_ready, rsp_valid, bus_stb;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] bus_addr;
    logic          bus_ack  = 1'b0;
    logic [DW-1:0] bus_data = '0;

    cwf_refill_ctrl #(.DATA_W(DW), .ADDR_W(AW), .LINE_WORDS(NW), .SETS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .bus_stb(bus_stb), .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_data(bus_data));

    int checks = 0;
    int errors = 0;

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return 32'h0000_9E37 * {22'd0, a} + 32'h1234_5670;
    endfunction

    // Bus model and monitor state.
    logic [AW-1:0] q_addr [16];
    int            q_age  [16];
    int            q_n = 0;
    int            lat = 1;
    bit            gap = 1'b0;
    int            tick = 0;
    int            stb_n = 0;
    int            ack_n = 0;
    int            rsp_n = 0;
    logic [AW-1:0] stb_log [256];
    int            stb_ack [256];
    logic [DW-1:0] rsp_log [64];
    int            rsp_acks [64];

    // Monitor outputs first, then drive the bus acknowledge for the coming edge.
    always @(negedge clk) begin
        tick++;
        if (rst_n) begin
            if (rsp_valid) begin
                rsp_log[rsp_n % 64]  = rsp_data;
                rsp_acks[rsp_n % 64] = ack_n;
                rsp_n++;
            end
            bus_ack = 1'b0;
            if (q_n > 0 && q_age[0] >= lat && !(gap && (tick % 3 == 0))) begin
                bus_ack  = 1'b1;
                bus_data = mem_word(q_addr[0]);
                for (int i = 0; i < 15; i++) begin
                    q_addr[i] = q_addr[i+1];
                    q_age[i]  = q_age[i+1];
                end
                q_n--;
                ack_n++;
            end
            for (int i = 0; i < q_n; i++) q_age[i]++;
            if (bus_stb) begin
                q_addr[q_n] = bus_addr;
                q_age[q_n]  = 0;
                q_n++;
                stb_log[stb_n % 256] = bus_addr;
                stb_ack[stb_n % 256] = ack_n;
                stb_n++;
            end
        end else begin
            bus_ack = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Present one request from a negedge; it is taken at the next edge where ready is high.
    task automatic send(input logic [AW-1:0] a);
        for (int k = 0; k < 100 && !req_ready; k++) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_acks(input int target);
        for (int k = 0; k < 2000 && ack_n < target; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Check that strobes from log index sb are a wrapped burst over line a.
    task automatic chk_burst(input int sb, input logic [AW-1:0] a, input string req);
        int bad = 0;
        logic [AW-1:0] exp_a;
        for (int i = 0; i < NW; i++) begin
            exp_a = {a[AW-1:3], 3'(a[2:0] + 3'(i))};
            if (stb_log[(sb + i) % 256] != exp_a) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    function automatic logic [AW-1:0] mk(input int tag, input int idx, input int wd);
        return {5'(tag), 2'(idx), 3'(wd)};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(bus_stb == 1'b0, "R1 no strobe after reset", bus_stb, 0);
        chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);

        // Sweep every start word with varied ack latency and gaps (R2, R3, R8, R9).
        for (int w = 0; w < NW; w++) begin
            logic [AW-1:0] a, h;
            int sb, ab, rb;
            a = mk(w + 1, w % 4, w);
            lat = w % 3;
            gap = w[0];
            sb = stb_n; ab = ack_n; rb = rsp_n;
            send(a);
            wait_acks(ab + NW);
            chk(stb_n - sb == NW, "R2 strobe count (R9 miss)", stb_n - sb, NW);
            chk_burst(sb, a, "R2 wrapped order");
            chk(rsp_n - rb == 1, "R3 one response", rsp_n - rb, 1);
            chk(rsp_log[rb % 64] == mem_word(a), "R3 critical data", rsp_log[rb % 64], mem_word(a));
            chk(rsp_acks[rb % 64] - ab == 1, "R3 answered after first ack", rsp_acks[rb % 64] - ab, 1);
            // Idle hit on another word of the line.
            h = mk(w + 1, w % 4, (w + 5) % NW);
            sb = stb_n;
            send(h);
            chk(rsp_valid == 1'b1 && rsp_data == mem_word(h), "R8 idle hit data", rsp_data, mem_word(h));
            repeat (2) @(negedge clk);
            chk(stb_n == sb, "R8 hit no bus read", stb_n - sb, 0);
        end

        // Set conflict: set 0 now holds tag 5, so tag 1 must miss (R9).
        begin
            int sb, ab;
            lat = 0; gap = 1'b0;
            sb = stb_n; ab = ack_n;
            send(mk(1, 0, 2));
            wait_acks(ab + NW);
            chk(stb_n - sb == NW, "R9 conflict miss refills", stb_n - sb, NW);
            chk_burst(sb, mk(1, 0, 2), "R9 conflict wrapped order");
        end

        // Tail request to the same line: held, replayed after the refill, then hits (R4, R5, R6).
        begin
            logic [AW-1:0] a, b;
            int sb, ab, rb;
            lat = 2; gap = 1'b1;
            a = mk(9, 2, 6);
            b = mk(9, 2, 1);
            sb = stb_n; ab = ack_n; rb = rsp_n;
            send(a);
            for (int k = 0; k < 200 && !rsp_valid; k++) @(negedge clk);
            chk(req_ready == 1'b1, "R4 slot freed after early response", req_ready, 1);
            chk(ack_n - ab < NW, "R4 acks still pending at early response", ack_n - ab, NW - 1);
            send(b);
            chk(req_ready == 1'b0, "R5 ready low while request held", req_ready, 0);
            chk(ack_n - ab < NW, "R5 hold taken during tail", ack_n - ab, NW - 1);
            wait_acks(ab + NW);
            chk(rsp_n - rb == 2, "R6 two responses", rsp_n - rb, 2);
            chk(rsp_acks[(rb + 1) % 64] - ab == NW, "R6 replay after last ack", rsp_acks[(rb + 1) % 64] - ab, NW);
            chk(rsp_log[(rb + 1) % 64] == mem_word(b), "R6 replay data", rsp_log[(rb + 1) % 64], mem_word(b));
            chk(stb_n - sb == NW, "R6 replay hit, no new reads", stb_n - sb, NW);
        end

        // Tail request to another line: it refills only after the first refill ends (R7).
        begin
            logic [AW-1:0] a, b;
            int sb, ab, rb;
            lat = 1; gap = 1'b1;
            a = mk(12, 1, 3);
            b = mk(20, 3, 7);
            sb = stb_n; ab = ack_n; rb = rsp_n;
            send(a);
            for (int k = 0; k < 200 && !rsp_valid; k++) @(negedge clk);
            send(b);
            wait_acks(ab + 2 * NW);
            chk(stb_n - sb == 2 * NW, "R7 two full bursts", stb_n - sb, 2 * NW);
            chk_burst(sb + NW, b, "R7 second burst wrapped order");
            chk(stb_ack[(sb + NW) % 256] - ab >= NW, "R7 second burst after all acks",
                stb_ack[(sb + NW) % 256] - ab, NW);
            chk(rsp_log[(rb + 1) % 64] == mem_word(b), "R7 second critical data",
                rsp_log[(rb + 1) % 64], mem_word(b));
            chk(bus_stb == 1'b0 && req_ready == 1'b1, "R1 idle quiet after refills", bus_stb, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end
endmodule